// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches 23 asynchronous request lines. Each line is brought into the clock domain through two flops. Edges are then found by comparing the synchronised level with its value one clock earlier. Per line, software selects rising edges, falling edges or both.

A detected edge then feeds two paths, and each path has its own mask:
- The interrupt path latches a pending bit. The line's request output stays high while that bit is set and the line is unmasked.
- The event path gives a one-clock pulse and never touches the pending bit.

Software can also fire any line through a self-clearing trigger register.

Configuration goes through a small APB-style slave that takes 32-bit word accesses. A three-state access tracker, with states IDLE, SETUP and ACCESS, accepts a write only in an access phase that follows a setup phase. Its transitions are:
- IDLE to SETUP on a select with the enable low.
- SETUP to ACCESS when the enable rises.
- SETUP to IDLE if the select drops.
- ACCESS back to SETUP on a new setup.
- ACCESS to IDLE otherwise.

Top module: `edge_line_ctrl`

## Requirements
- R1: Lines 0 to 22 each own bit n of every register. Bits 31:23 read as zero, and writes to them are dropped.
- R2: The word offsets are fixed:
  - 0x00 is the interrupt mask.
  - 0x04 is the event mask.
  - 0x08 is the rising select.
  - 0x0C is the falling select.
  - 0x10 is the software trigger.
  - 0x14 is the pending status.
  
  Reads from any other offset return zero.
- R3: After reset, every register reads zero, and `irq_o` and `evt_o` are zero.
- R4: A line triggers on a rising edge when its rising-select bit is 1 and on a falling edge when its falling-select bit is 1. With both bits at 1, either edge triggers. An input change made between two clock edges shows on the outputs after the third following rising clock edge.
- R5: A trigger on a line whose interrupt-mask bit is 1 sets its pending bit. `irq_o[n]` equals pending[n] AND interrupt-mask[n].
- R6: A trigger on a line whose event-mask bit is 1 makes `evt_o[n]` high for exactly one clock. The event path alone never sets a pending bit.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A write to the rising or falling select register clears the pending bit of every line whose select bit changes value. A write that keeps a bit's value leaves that line's pending bit alone.
- R8: Writing 1 to a software-trigger bit that reads 0 does three things:
  - It sets the pending bit, even when the interrupt mask is 0.
  - It pulses `evt_o` if the line's event mask is 1.
  - It leaves the trigger bit reading 1 until the pending bit is cleared, and the trigger bit then clears with it.
- R9: A rising edge seen in the same cycle as a rising-select write is judged by the old select value, and it still sets the pending bit. A falling edge seen in the same cycle as a falling-select write sets nothing.
- R10: If a hardware trigger and a clear of the same pending bit fall in the same cycle, the bit ends set.
- R11: A write takes effect only when an enabled access phase follows a setup phase. An enabled write cycle with no setup before it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address (word aligned) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| line_in | input | 23 | Asynchronous request lines |
| irq_o | output | 23 | Per-line interrupt request level |
| evt_o | output | 23 | Per-line one-clock event pulse |

## Verification
The embedded properties check the following on every cycle:
- A pending bit only rises after a hardware set or a software set in the cycle before.
- A pending bit only falls after a clear request.
- A hardware set always leaves its bit high.
- A software-trigger bit never stands without its pending bit.
- An event pulse never appears on a line that was event-masked.
- A write never commits without a preceding setup phase.

Only the bench scenarios can show the following:
- The exact three-edge latency.
- Edge selection per polarity.
- The one-clock width of each pulse.
- The same-cycle select-write races.
- The rule that a changed select bit clears its pending bit while an unchanged one does not.

// File: rtl/exti_pkg.sv
package exti_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apb_st_e;

    typedef enum logic [2:0] {
        RIDX_IMASK = 3'd0,
        RIDX_EMASK = 3'd1,
        RIDX_RISE  = 3'd2,
        RIDX_FALL  = 3'd3,
        RIDX_SWTRG = 3'd4,
        RIDX_PEND  = 3'd5
    } reg_idx_e;

endpackage

// File: rtl/line_edge_det.sv
module line_edge_det #(
    parameter int N = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1_q, s2_q, s3_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[g] <= 1'b0;
                s2_q[g] <= 1'b0;
                s3_q[g] <= 1'b0;
            end else begin
                s1_q[g] <= din[g];
                s2_q[g] <= s1_q[g];
                s3_q[g] <= s2_q[g];
            end
        end
        assign rise[g] = s2_q[g] & ~s3_q[g];
        assign fall[g] = ~s2_q[g] & s3_q[g];
    end
endmodule

// File: rtl/apb_regfile.sv
module apb_regfile
    import exti_pkg::*;
#(
    parameter int N      = 23,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      swtrg,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      imask,
    output logic [N-1:0]      emask,
    output logic [N-1:0]      rsel,
    output logic [N-1:0]      fsel,
    output logic              wr_rise,
    output logic              wr_fall,
    output logic              wr_swtrg,
    output logic              wr_pend
);
    localparam int IW = ADDR_W - 2;

    apb_st_e       st_q, st_d;
    logic [IW-1:0] idx;
    logic          aligned;
    logic          wr_stb;
    logic          wr_im, wr_em;

    assign idx     = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);

    // access tracker: next state
    always_comb begin
        st_d = ST_IDLE;
        unique case (st_q)
            ST_IDLE:   st_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  st_d = !psel ? ST_IDLE : (penable ? ST_ACCESS : ST_SETUP);
            ST_ACCESS: st_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // access tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // access tracker: outputs (write strobes)
    always_comb begin
        wr_stb   = (st_q == ST_SETUP) && psel && penable && pwrite && aligned;
        wr_im    = wr_stb && (idx == IW'(RIDX_IMASK));
        wr_em    = wr_stb && (idx == IW'(RIDX_EMASK));
        wr_rise  = wr_stb && (idx == IW'(RIDX_RISE));
        wr_fall  = wr_stb && (idx == IW'(RIDX_FALL));
        wr_swtrg = wr_stb && (idx == IW'(RIDX_SWTRG));
        wr_pend  = wr_stb && (idx == IW'(RIDX_PEND));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask <= '0;
            emask <= '0;
            rsel  <= '0;
            fsel  <= '0;
        end else begin
            if (wr_im)   imask <= wdata;
            if (wr_em)   emask <= wdata;
            if (wr_rise) rsel  <= wdata;
            if (wr_fall) fsel  <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (psel && !pwrite && aligned) begin
            case (idx)
                IW'(RIDX_IMASK): rdata = imask;
                IW'(RIDX_EMASK): rdata = emask;
                IW'(RIDX_RISE):  rdata = rsel;
                IW'(RIDX_FALL):  rdata = fsel;
                IW'(RIDX_SWTRG): rdata = swtrg;
                IW'(RIDX_PEND):  rdata = pend;
                default:         rdata = '0;
            endcase
        end
    end

    // R11: a committed write must have a setup phase in the cycle before
    p_write_after_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(psel && !penable));

endmodule

// File: rtl/pend_ctl.sv
module pend_ctl #(
    parameter int N = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] imask,
    input  logic [N-1:0] emask,
    input  logic [N-1:0] rsel,
    input  logic [N-1:0] fsel,
    input  logic         wr_rise,
    input  logic         wr_fall,
    input  logic         wr_swtrg,
    input  logic         wr_pend,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] pend,
    output logic [N-1:0] swtrg,
    output logic [N-1:0] evt
);
    logic [N-1:0] hw_trig, hw_set, sw_set, sense_clr, w1c, clr, set_all, clr_eff;

    always_comb begin
        // a falling edge in a falling-select write cycle is discarded
        hw_trig   = (rise & rsel) | (fall & fsel & ~{N{wr_fall}});
        hw_set    = hw_trig & imask;
        sw_set    = {N{wr_swtrg}} & wdata & ~swtrg;
        sense_clr = ({N{wr_rise}} & (wdata ^ rsel)) | ({N{wr_fall}} & (wdata ^ fsel));
        w1c       = {N{wr_pend}} & wdata;
        clr       = sense_clr | w1c;
        set_all   = hw_set | sw_set;
        clr_eff   = clr & ~set_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= '0;
            swtrg <= '0;
            evt   <= '0;
        end else begin
            pend  <= (pend & ~clr_eff) | set_all;
            swtrg <= (swtrg & ~clr_eff) | sw_set;
            evt   <= (hw_trig | sw_set) & emask;
        end
    end

    // R5: a pending bit only rises after a set source in the prior cycle
    p_pend_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(set_all)) == '0);

    // R7: a pending bit only falls after a clear request
    p_pend_clear_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~pend & ~$past(clr)) == '0);

    // R10: a hardware set always leaves the bit high
    p_hw_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hw_set) & ~pend) == '0);

    // R8: a software trigger bit never stands without its pending bit
    p_swtrg_in_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swtrg & ~pend) == '0);

    // R6: no event pulse on a line that was event-masked
    p_evt_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & ~$past(emask)) == '0);

endmodule

// File: rtl/edge_line_ctrl.sv
module edge_line_ctrl #(
    parameter int NUM_LINES = 23,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] irq_o,
    output logic [NUM_LINES-1:0] evt_o
);
    localparam int PAD = DATA_W - NUM_LINES;

    logic [NUM_LINES-1:0] rise, fall, imask, emask, rsel, fsel, pend, swtrg, rdata;
    logic                 wr_rise, wr_fall, wr_swtrg, wr_pend;

    line_edge_det #(.N(NUM_LINES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .rise (rise),
        .fall (fall)
    );

    apb_regfile #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wdata   (pwdata[NUM_LINES-1:0]),
        .pend    (pend),
        .swtrg   (swtrg),
        .rdata   (rdata),
        .imask   (imask),
        .emask   (emask),
        .rsel    (rsel),
        .fsel    (fsel),
        .wr_rise (wr_rise),
        .wr_fall (wr_fall),
        .wr_swtrg(wr_swtrg),
        .wr_pend (wr_pend)
    );

    pend_ctl #(.N(NUM_LINES)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .fall    (fall),
        .imask   (imask),
        .emask   (emask),
        .rsel    (rsel),
        .fsel    (fsel),
        .wr_rise (wr_rise),
        .wr_fall (wr_fall),
        .wr_swtrg(wr_swtrg),
        .wr_pend (wr_pend),
        .wdata   (pwdata[NUM_LINES-1:0]),
        .pend    (pend),
        .swtrg   (swtrg),
        .evt     (evt_o)
    );

    assign prdata = {{PAD{1'b0}}, rdata};
    assign irq_o  = pend & imask;

endmodule

// File: tb/tb_edge_line_ctrl.sv
module tb_edge_line_ctrl;
    localparam int N = 23;
    localparam logic [7:0] A_IM = 8'h00, A_EM = 8'h04, A_RS = 8'h08,
                           A_FS = 8'h0C, A_SW = 8'h10, A_PD = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [N-1:0] line_in = '0;
    logic [N-1:0] irq_o, evt_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    edge_line_ctrl dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .line_in(line_in), .irq_o(irq_o), .evt_o(evt_o)
    );

    typedef struct packed {
        logic [4:0] ln;
        logic       re;
        logic       fe;
        logic       im;
        logic       em;
        logic       up;
        logic       x_irq;
        logic       x_evt;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{5'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{5'd13, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{5'd13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{5'd22, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        chk("R3 irq after reset", 32'(irq_o), 32'h0);
        chk("R3 evt after reset", 32'(evt_o), 32'h0);
        for (int a = 0; a < 6; a++) begin
            apb_read(8'(a * 4), rd);
            chk("R3 register reset value", rd, 32'h0);
        end

        // R1: reserved bits
        apb_write(A_IM, 32'hFFFF_FFFF);
        apb_read(A_IM, rd);
        chk("R1 reserved bits read zero", rd, 32'h007F_FFFF);

        // R2: offsets
        apb_write(A_IM, 32'h0000_0005);
        apb_read(A_EM, rd);
        chk("R2 event mask separate", rd, 32'h0);
        apb_read(A_IM, rd);
        chk("R2 irq mask offset", rd, 32'h5);
        apb_read(8'h18, rd);
        chk("R2 unmapped offset", rd, 32'h0);
        apb_write(A_IM, 32'h0);

        // table walk: R4 R5 R6
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            line_in[VT[v].ln] = ~VT[v].up;
            settle();
            apb_write(A_RS, 32'(VT[v].re) << VT[v].ln);
            apb_write(A_FS, 32'(VT[v].fe) << VT[v].ln);
            apb_write(A_IM, 32'(VT[v].im) << VT[v].ln);
            apb_write(A_EM, 32'(VT[v].em) << VT[v].ln);
            apb_write(A_PD, 32'hFFFF_FFFF);
            line_in[VT[v].ln] = VT[v].up;
            repeat (3) @(negedge clk);
            chk("R4/R5 irq after edge", 32'(irq_o[VT[v].ln]), 32'(VT[v].x_irq));
            chk("R4/R6 evt after edge", 32'(evt_o[VT[v].ln]), 32'(VT[v].x_evt));
            @(negedge clk);
            chk("R6 evt one clock", 32'(evt_o[VT[v].ln]), 32'h0);
        end

        // R6: event path leaves pending clear
        @(negedge clk); line_in[3] = 1'b0; settle();
        apb_write(A_RS, 32'h8);
        apb_write(A_FS, 32'h0);
        apb_write(A_IM, 32'h0);
        apb_write(A_EM, 32'h8);
        apb_write(A_PD, 32'hFFFF_FFFF);
        line_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 event pulse", 32'(evt_o[3]), 32'h1);
        apb_read(A_PD, rd);
        chk("R6 event does not set pending", rd, 32'h0);

        // R7: write-one-to-clear and select-change clear
        @(negedge clk); line_in[4] = 1'b0; settle();
        apb_write(A_RS, 32'h10);
        apb_write(A_IM, 32'h10);
        apb_write(A_EM, 32'h0);
        apb_write(A_PD, 32'hFFFF_FFFF);
        line_in[4] = 1'b1;
        settle();
        apb_read(A_PD, rd);
        chk("R7 pending set", rd, 32'h10);
        apb_write(A_PD, 32'h0);
        apb_read(A_PD, rd);
        chk("R7 write 0 no effect", rd, 32'h10);
        apb_write(A_PD, 32'h10);
        apb_read(A_PD, rd);
        chk("R7 write 1 clears", rd, 32'h0);
        line_in[4] = 1'b0; settle();
        line_in[4] = 1'b1; settle();
        apb_write(A_RS, 32'h10);
        apb_read(A_PD, rd);
        chk("R7 unchanged select keeps pending", rd, 32'h10);
        apb_write(A_RS, 32'h0);
        apb_read(A_PD, rd);
        chk("R7 changed select clears pending", rd, 32'h0);

        // R8: software trigger
        apb_write(A_IM, 32'h200);
        apb_write(A_EM, 32'h200);
        apb_write(A_SW, 32'h200);
        chk("R8 sw irq", 32'(irq_o[9]), 32'h1);
        chk("R8 sw event pulse", 32'(evt_o[9]), 32'h1);
        @(negedge clk);
        chk("R8 sw event one clock", 32'(evt_o[9]), 32'h0);
        apb_read(A_SW, rd);
        chk("R8 sw bit holds", rd, 32'h200);
        apb_write(A_PD, 32'h200);
        apb_read(A_SW, rd);
        chk("R8 sw bit self-clears", rd, 32'h0);
        chk("R8 irq dropped", 32'(irq_o[9]), 32'h0);
        apb_write(A_IM, 32'h0);
        apb_write(A_SW, 32'h400);
        apb_read(A_PD, rd);
        chk("R8 sw sets pending while masked", rd, 32'h400);
        chk("R8 masked irq low", 32'(irq_o[10]), 32'h0);
        apb_write(A_PD, 32'hFFFF_FFFF);

        // R9: rising edge during rising-select write
        @(negedge clk); line_in[12] = 1'b0; settle();
        apb_write(A_RS, 32'h1000);
        apb_write(A_FS, 32'h0);
        apb_write(A_IM, 32'h1000);
        apb_write(A_PD, 32'hFFFF_FFFF);
        line_in[12] = 1'b1;
        apb_write(A_RS, 32'h0);
        chk("R9 rise during select write sets", 32'(irq_o[12]), 32'h1);
        // R9: falling edge during falling-select write
        settle();
        apb_write(A_FS, 32'h1000);
        apb_write(A_PD, 32'hFFFF_FFFF);
        line_in[12] = 1'b0;
        apb_write(A_FS, 32'h1000);
        settle();
        chk("R9 fall during select write ignored", 32'(irq_o[12]), 32'h0);

        // R10: hardware set beats clear
        @(negedge clk); line_in[15] = 1'b0; settle();
        apb_write(A_RS, 32'h8000);
        apb_write(A_FS, 32'h0);
        apb_write(A_IM, 32'h8000);
        apb_write(A_PD, 32'hFFFF_FFFF);
        line_in[15] = 1'b1;
        apb_write(A_PD, 32'h8000);
        chk("R10 set wins over clear", 32'(irq_o[15]), 32'h1);

        // R11: enabled write without setup phase is dropped
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = A_IM; pwdata = 32'h1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        apb_read(A_IM, rd);
        chk("R11 no write without setup", rd, 32'h8000);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule